// File: doc/BRIEF.md
# Delay-Matching Successive-Approximation Controller

This block searches, one bit per reference clock period, for the tap-select code that makes a delay line's total delay equal one reference period. The delay line has a fixed coarse section plus a fine section. The length of the fine section is set by the code, which drives an external tap multiplexer. A flip-flop outside the block compares the reference edge with the delayed edge and returns a single early/late decision. The controller uses that decision to keep or drop the bit under trial, and then moves on to the next lower bit.

A conversion begins on a rising edge of an asynchronous start request. The request is synchronised inside the block, so a held level does not retrigger it. The search tests the most significant bit first and lasts exactly as many cycles as the code has bits. The finished code stays on the tap output and on a separate result port, and a single-cycle done pulse marks it, until the next conversion begins. The tap code changes only at reference clock edges, so the external comparator always judges a tap that has been steady for a whole period.

Top module: `delay_sar_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, tap_code_o and result_o are 0 and busy_o and done_o are 0.
- R2: start_i passes through a two-flop synchroniser. busy_o rises on the third rising clock edge after start_i is first sampled high. A level that stays high starts only one conversion.
- R3: busy_o stays high for exactly W consecutive cycles per conversion (W = 9 by default).
- R4: On the first busy cycle, tap_code_o has only its most significant bit set (value 256 for W = 9).
- R5: Each busy cycle judges the bit under trial. When late_i = 1 (delay too long) that bit is cleared, and when late_i = 0 it is kept. The next lower bit is then set as the new trial, so between two busy cycles at most two code bits change.
- R6: tap_code_o changes only at a clock edge that is inside, starts or ends a conversion. While the block is idle it is stable.
- R7: done_o is high for exactly one cycle, the cycle right after busy_o falls. In that cycle result_o equals tap_code_o.
- R8: result_o and tap_code_o keep their values until the next conversion starts, whatever late_i does in the meantime.
- R9: Rising edges of start_i while busy_o is high are ignored. They neither restart nor extend the conversion.
- R10: If late_i is 1 exactly for codes above a threshold t, the final code equals min(t, 2^W − 1). This includes t = 0 and the all-ones code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Asynchronous start request, acts on its rising edge |
| late_i | input | 1 | Registered phase decision: 1 when the delayed edge comes after the reference edge |
| tap_code_o | output | W | Trial or final code to the fine-tap multiplexer |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the final code is ready |
| result_o | output | W | Final code of the last conversion |

## Verification
Several properties are checked on every cycle. The conversion length is checked against a counter kept in the checker. The first trial code, the change of at most two bits between busy cycles, idle stability of the tap code, the shape of the done pulse and the agreement of result and tap code at done are also checked continuously. Other behaviours can only be shown by the bench's scenarios: the exact start latency through the synchroniser, that a held start level or a mid-conversion start edge is ignored, and that the search lands on the right threshold code, including both ends of the range. The bench shows these against a behavioural model with several thresholds.

// File: rtl/dsar_pkg.sv
package dsar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dsar_state_e;
endpackage

// File: rtl/dsar_start_sync.sv
module dsar_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= req_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign req_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/dsar_seq.sv
module dsar_seq
  import dsar_pkg::*;
#(
  parameter int W  = 9,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          load,
  output logic          step,
  output logic          last,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  dsar_state_e state_q;
  logic [IW-1:0] idx_q;
  logic done_q;

  assign busy = (state_q == ST_RUN);
  assign load = (state_q == ST_IDLE) && go;
  assign step = busy;
  assign last = busy && (idx_q == '0);
  assign idx  = idx_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_RUN;
            idx_q   <= TOP_IDX;
          end
        end
        ST_RUN: begin
          if (idx_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsar_code.sv
module dsar_code #(
  parameter int W  = 9,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          last,
  input  logic [IW-1:0] idx,
  input  logic          late,
  output logic [W-1:0]  code,
  output logic [W-1:0]  result
);
  logic [W-1:0] code_q, result_q, code_d;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      localparam logic [IW-1:0] SELF = IW'(b);
      localparam logic [IW-1:0] ABOVE = IW'(b + 1);
      always_comb begin
        if (load) begin
          code_d[b] = (b == W - 1);
        end else if (step && idx == SELF) begin
          code_d[b] = code_q[b] & ~late;
        end else if (step && (b < W - 1) && idx == ABOVE) begin
          code_d[b] = 1'b1;
        end else begin
          code_d[b] = code_q[b];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      result_q <= '0;
    end else begin
      code_q <= code_d;
      if (last) result_q <= code_d;
    end
  end

  assign code   = code_q;
  assign result = result_q;
endmodule

// File: rtl/delay_sar_ctrl.sv
module delay_sar_ctrl #(
  parameter int W           = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         late_i,
  output logic [W-1:0] tap_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic          go, load, step, last;
  logic [IW-1:0] idx;

  dsar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .req_async(start_i),
    .req_rise (go)
  );

  dsar_seq #(.W(W), .IW(IW)) u_seq (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .load(load),
    .step(step),
    .last(last),
    .idx (idx),
    .busy(busy_o),
    .done(done_o)
  );

  dsar_code #(.W(W), .IW(IW)) u_code (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .last  (last),
    .idx   (idx),
    .late  (late_i),
    .code  (tap_code_o),
    .result(result_o)
  );
endmodule

// File: rtl/dsar_checker.sv
module dsar_checker #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] tap_code_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int CW = $clog2(W + 2);
  localparam logic [W-1:0] MSB_ONLY = W'(1) << (W - 1);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> run_cnt == CW'(W));

  p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> tap_code_o == MSB_ONLY);

  p_bit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $countones(tap_code_o ^ $past(tap_code_o)) <= 2);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(!busy_o)) |-> $stable(tap_code_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  p_done_match_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> result_o == tap_code_o);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
endmodule

bind delay_sar_ctrl dsar_checker #(.W(W)) u_dsar_checker (
  .clk       (clk),
  .rst       (rst),
  .tap_code_o(tap_code_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/tb_delay_sar_ctrl.sv
module tb_delay_sar_ctrl;
  localparam int W = 9;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic late_i;
  logic [W-1:0] tap_code_o, result_o;
  logic busy_o, done_o;
  int thr = 0;
  int n_chk = 0;
  int n_fail = 0;
  int done_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign late_i = (int'(tap_code_o) > thr);

  delay_sar_ctrl #(.W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .late_i(late_i),
    .tap_code_o(tap_code_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit hist[$] = '{0, 0, 0};
  int m_code = 0, m_res = 0, m_bit = 0;
  bit m_busy = 0, m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0};
      m_code = 0; m_res = 0; m_bit = 0; m_busy = 0; m_done = 0;
    end else begin
      bit rise;
      rise = hist[1] && !hist[2];
      hist.push_front(start_i);
      void'(hist.pop_back());
      m_done = 0;
      if (m_busy) begin
        if (m_code > thr) m_code = m_code & ~(1 << m_bit);
        if (m_bit > 0) begin
          m_bit = m_bit - 1;
          m_code = m_code | (1 << m_bit);
        end else begin
          m_busy = 0;
          m_done = 1;
          m_res = m_code;
        end
      end else if (rise) begin
        m_busy = 1;
        m_bit = W - 1;
        m_code = 1 << (W - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(m_busy ? "R3 busy" : "R2 busy", int'(busy_o), int'(m_busy));
      chk("R5 tap code", int'(tap_code_o), m_code);
      chk("R7 done", int'(done_o), int'(m_done));
      chk("R8 result", int'(result_o), m_res);
      if (done_o) done_seen++;
    end
  end

  task automatic convert(input int t, input bit mid_pulse);
    int lat = 0;
    int blen = 0;
    thr = t;
    @(negedge clk);
    start_i = 1'b1;
    while (!busy_o && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk("R2 start latency", lat, 3);
    chk("R4 first trial", int'(tap_code_o), 1 << (W - 1));
    start_i = 1'b0;
    while (busy_o && blen < 20) begin
      blen++;
      if (mid_pulse && blen == 3) start_i = 1'b1;
      if (mid_pulse && blen == 6) start_i = 1'b0;
      @(negedge clk);
    end
    chk("R3 busy length", blen, W);
    chk("R7 done after busy", int'(done_o), 1);
    chk("R10 final code", int'(result_o), (t < MAXC) ? t : MAXC);
    repeat (8) @(negedge clk);
    chk("R9 no restart", int'(busy_o), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(tap_code_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 result in reset", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code after reset", int'(tap_code_o), 0);

    convert(300, 0);
    convert(0, 0);
    convert(MAXC, 0);
    convert(700, 0);
    convert(255, 0);
    convert(256, 0);
    convert(1, 0);

    d0 = done_seen;
    convert(137, 1);
    chk("R9 one done per conversion", done_seen - d0, 1);

    // R8: late_i varies while idle, outputs must not move
    thr = 0;
    repeat (5) @(negedge clk);
    chk("R8 result held", int'(result_o), 137);
    chk("R6 tap held", int'(tap_code_o), 137);

    // R2: a held level starts only one conversion
    d0 = done_seen;
    thr = 400;
    start_i = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 held level single run", done_seen - d0, 1);
    chk("R10 final code held level", int'(result_o), 400);
    start_i = 1'b0;
    repeat (5) @(negedge clk);

    for (int k = 0; k < 6; k++) convert((k * 97 + 13) % 520, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule